// File: doc/BRIEF.md
# AXI4 Burst Read to Single-Cycle Strobe Bridge

This block terminates the read half of an AXI4 slave port and turns each read burst into a train of one-cycle read strobes, each carrying a word address, toward a simple downstream register or memory slave. That slave cannot stall. It returns its data exactly one clock after a strobe and holds that data until the next strobe. The bridge presents this data on the R channel together with the burst ID and the last-beat flag. All AXI-side control outputs come from registers.

The aim is full return bandwidth: one beat per clock across consecutive bursts, single-beat bursts included. To reach it, the first word is read in the same cycle as the address handshake. ARREADY is raised again one beat before the final beat of a burst. When a new request is accepted while the previous burst's final beat is stalled on R, that beat is counted into the new burst's remaining-beat count. No separate holding register is needed. FIXED, INCR and WRAP address sequences are generated. The response code is always OKAY.

Top module: `axi_burst_read_bridge`

## Requirements
- R1: After reset, and whenever RVALID is low, ARREADY is high. Reset leaves RVALID and RLAST low and the read strobe inactive.
- R2: An accepted request with ARLEN = 0 whose first word is read in the handshake cycle leaves ARREADY high on the next cycle. Any other accepted request drops ARREADY on the next cycle.
- R3: The read strobe is never active while R is stalled (RVALID high, RREADY low). When a request is accepted and R is not stalled, the strobe is active in that same cycle, with word address ARADDR >> log2(DATA_W/8).
- R4: Address step by ARBURST. 2'b00 (FIXED) repeats the start address. 2'b01 (INCR) moves to the next address aligned to 2^ARSIZE bytes. 2'b10 (WRAP) steps the same way but wraps inside a window of (ARLEN+1)*2^ARSIZE bytes aligned to its own size.
- R5: Every burst returns exactly ARLEN+1 beats for any ARLEN from 0 to 255. RVALID is high exactly while beats remain, including a merged total of 257 beats.
- R6: With ARVALID and RREADY held high, consecutive bursts of mixed lengths, length one included, return one beat on every clock with no idle cycle. ARREADY is high in every cycle in which RLAST rises.
- R7: While RVALID is high and RREADY is low, RVALID, RLAST, RID and RDATA keep their values on the next cycle.
- R8: A request accepted while the previous burst's final beat is stalled drops ARREADY. ARREADY stays low, so no third request is taken, until that beat has left. The stalled beat keeps its RID and RLAST.
- R9: RLAST is high only on the final beat of each burst. RID equals the ARID of the burst the beat belongs to. RDATA equals the downstream data for that beat's address.
- R10: RRESP is always 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Byte address of first beat |
| arlen | input | 8 | Beats minus one |
| arsize | input | 3 | log2 of bytes per beat |
| arburst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping |
| arid | input | ID_W | Transaction ID |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rid | output | ID_W | ID of the returned beat |
| rlast | output | 1 | Final beat of a burst |
| rresp | output | 2 | Response code, always OKAY |
| rd_stb | output | 1 | Single-cycle downstream read strobe |
| rd_word_addr | output | ADDR_W-log2(DATA_W/8) | Downstream word address |
| rd_word_data | input | DATA_W | Downstream data, valid the cycle after a strobe |

## Verification
The hardest state to reach is the one where two bursts are outstanding. The previous burst's final beat must be stalled on R at the very moment a new request is accepted, so that the stalled beat is counted into the new burst. The bench holds RREADY low, issues a one-beat burst, and keeps ARVALID high with a second, 256-beat burst. That request is taken while the first beat is still stalled, which drives the beat count to its 257 maximum. A third request is then held on AR to confirm it is refused until the stalled beat drains. A separate run with pseudo-random RREADY repeats the merge at many burst boundaries.

// File: rtl/axrb_pkg.sv
package axrb_pkg;

  localparam int LEN_W  = 8;
  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;

  typedef struct packed {
    burst_e              kind;
    logic [SIZE_W-1:0]   size;
    logic [LEN_W-1:0]    len;
  } burst_ctx_t;

endpackage

// File: rtl/axrb_addr_step.sv
module axrb_addr_step
  import axrb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  burst_ctx_t        ctx,
  output logic [ADDR_W-1:0] nxt_addr
);

  logic [ADDR_W-1:0] nbytes;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] bumped;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] wmask;

  always_comb begin
    nbytes  = ADDR_W'(1) << ctx.size;
    aligned = cur_addr & ~(nbytes - ADDR_W'(1));
    bumped  = aligned + nbytes;
    span    = (ADDR_W'(ctx.len) + ADDR_W'(1)) << ctx.size;
    wmask   = span - ADDR_W'(1);
    case (ctx.kind)
      BURST_FIXED: nxt_addr = cur_addr;
      BURST_WRAP:  nxt_addr = (cur_addr & ~wmask) | (bumped & wmask);
      default:     nxt_addr = bumped;
    endcase
  end

endmodule

// File: rtl/axrb_beat_ctr.sv
module axrb_beat_ctr #(
  parameter int LEN_W = 8,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             keep_one,
  input  logic             take,
  output logic             cnt_nz,
  output logic             cnt_is2
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'((1 << LEN_W) + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt_q;
    if (load) begin
      cnt_en  = 1'b1;
      cnt_nxt = CNT_W'(len) + CNT_W'(1) + CNT_W'(keep_one);
    end else if (take) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt_nz  = (cnt_q != '0);
  assign cnt_is2 = (cnt_q == CNT_W'(2));

  // R5: a beat is never taken from an empty count
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |-> (cnt_q != '0));

  // R5: merged count never exceeds a full burst plus one stalled beat
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

endmodule

// File: rtl/axi_burst_read_bridge.sv
module axi_burst_read_bridge
  import axrb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  localparam int LSB   = $clog2(DATA_W / 8),
  localparam int WA_W  = ADDR_W - LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [LEN_W-1:0]  arlen,
  input  logic [SIZE_W-1:0] arsize,
  input  logic [1:0]        arburst,
  input  logic [ID_W-1:0]   arid,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [ID_W-1:0]   rid,
  output logic              rlast,
  output logic [1:0]        rresp,
  output logic              rd_stb,
  output logic [WA_W-1:0]   rd_word_addr,
  input  logic [DATA_W-1:0] rd_word_data
);

  logic              arready_q, arready_nxt, arready_en;
  logic              rvalid_q, rvalid_nxt, rvalid_en;
  logic              rlast_q, rlast_nxt;
  logic [ID_W-1:0]   rid_q, rid_nxt;
  logic              out_en;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt, addr_cur, addr_step;
  logic              addr_en;
  burst_ctx_t        ctx_q, ctx_in, ctx_cur;
  logic              stall, accept, issue;
  logic              cnt_nz, cnt_is2;

  // ---------------- handshake decode ----------------
  always_comb begin
    stall       = rvalid_q & ~rready;
    accept      = arvalid & arready_q;
    issue       = ~stall & (accept | ~arready_q);
    ctx_in.kind = burst_e'(arburst);
    ctx_in.size = arsize;
    ctx_in.len  = arlen;
    ctx_cur     = arready_q ? ctx_in : ctx_q;
    addr_cur    = arready_q ? araddr : addr_q;
  end

  axrb_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr (addr_cur),
    .ctx      (ctx_cur),
    .nxt_addr (addr_step)
  );

  axrb_beat_ctr #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .len      (arlen),
    .keep_one (stall),
    .take     (rvalid_q & rready),
    .cnt_nz   (cnt_nz),
    .cnt_is2  (cnt_is2)
  );

  // ---------------- next state ----------------
  always_comb begin
    arready_en  = 1'b0;
    arready_nxt = arready_q;
    if (accept) begin
      arready_en  = 1'b1;
      arready_nxt = (arlen == '0) & issue;
    end else if (!stall && rvalid_q && !arready_q) begin
      arready_en  = 1'b1;
      arready_nxt = cnt_is2;
    end
  end

  always_comb begin
    addr_en  = 1'b0;
    addr_nxt = addr_q;
    if (accept) begin
      addr_en  = 1'b1;
      addr_nxt = issue ? addr_step : araddr;
    end else if (issue) begin
      addr_en  = 1'b1;
      addr_nxt = addr_step;
    end
  end

  always_comb begin
    rvalid_en  = issue | rready;
    rvalid_nxt = issue;
  end

  always_comb begin
    out_en = ~stall;
    if (accept) begin
      rlast_nxt = (arlen == '0);
      rid_nxt   = arid;
    end else begin
      rlast_nxt = cnt_is2;
      rid_nxt   = id_q;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          arready_q <= 1'b1;
    else if (arready_en) arready_q <= arready_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rvalid_q <= 1'b0;
    else if (rvalid_en) rvalid_q <= rvalid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rlast_q <= 1'b0;
      rid_q   <= '0;
    end else if (out_en) begin
      rlast_q <= rlast_nxt;
      rid_q   <= rid_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
      id_q  <= '0;
    end else if (accept) begin
      ctx_q <= ctx_in;
      id_q  <= arid;
    end
  end

  // ---------------- outputs ----------------
  assign arready      = arready_q;
  assign rvalid       = rvalid_q;
  assign rlast        = rlast_q;
  assign rid          = rid_q;
  assign rdata        = rd_word_data;
  assign rresp        = 2'b00;
  assign rd_stb       = issue;
  assign rd_word_addr = addr_cur[ADDR_W-1:LSB];

  // ---------------- assertions ----------------
  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_q |-> arready_q);

  p_no_read_in_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_q && !rready) |-> !rd_stb);

  p_valid_tracks_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q == cnt_nz);

  p_ready_at_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rlast_q) |-> arready_q);

  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_q && !rready) |=> (rvalid_q && $stable(rlast_q) && $stable(rid_q)));

  p_pair_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rvalid_q && !rready) |=> !arready_q);

endmodule

// File: tb/axi_burst_read_bridge_tb.sv
module axi_burst_read_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arvalid = 1'b0;
  logic        arready;
  logic [15:0] araddr = '0;
  logic [7:0]  arlen = '0;
  logic [2:0]  arsize = '0;
  logic [1:0]  arburst = '0;
  logic [3:0]  arid = '0;
  logic        rvalid;
  logic        rready = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  rid;
  logic        rlast;
  logic [1:0]  rresp;
  logic        rd_stb;
  logic [13:0] rd_word_addr;
  logic [31:0] rd_word_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  int rdy_mode = 0;
  int cyc = 0;
  int first_cyc = 0;
  int last_cyc = 0;
  bit seen_first = 1'b0;

  logic [13:0] exp_wa [0:1023];
  logic [3:0]  exp_id [0:1023];
  logic        exp_last [0:1023];
  int wp = 0;
  int rp = 0;

  always #4 clk = ~clk;

  axi_burst_read_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .arsize(arsize), .arburst(arburst), .arid(arid),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rid(rid),
    .rlast(rlast), .rresp(rresp),
    .rd_stb(rd_stb), .rd_word_addr(rd_word_addr), .rd_word_data(rd_word_data)
  );

  function automatic logic [31:0] pat(input logic [13:0] w);
    return {w, 4'hC, w} ^ 32'h3C5A_0000;
  endfunction

  function automatic logic [15:0] exp_next(input logic [15:0] a, input logic [1:0] b,
                                           input logic [2:0] s, input logic [7:0] l);
    int unsigned nb, base, span, ua;
    ua   = int'(a);
    nb   = 1 << s;
    base = ua - (ua % nb);
    span = (int'(l) + 1) * nb;
    if (b == 2'b00) return a;
    if (b == 2'b10) return 16'((ua - (ua % span)) + ((base + nb) % span));
    return 16'(base + nb);
  endfunction

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // downstream slave: one-cycle latency, holds data between strobes
  initial begin
    forever begin
      @(posedge clk);
      if (rd_stb) rd_word_data <= pat(rd_word_addr);
    end
  end

  // RREADY driver
  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
        0:       rready = 1'b0;
        1:       rready = 1'b1;
        default: rready = lfsr[0] | lfsr[3];
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    logic [15:0] pa;
    bit          p_stall;
    logic        p_last;
    logic [3:0]  p_id;
    logic [31:0] p_data;
    p_stall = 1'b0; p_last = 1'b0; p_id = '0; p_data = '0;
    forever begin
      @(negedge clk); #3;
      if (rst_n) begin
        cyc++;
        if (p_stall) begin
          chk_eq("R7", "rvalid held", 64'(rvalid), 64'd1);
          chk_eq("R7", "rlast held", 64'(rlast), 64'(p_last));
          chk_eq("R7", "rid held", 64'(rid), 64'(p_id));
          chk_eq("R7", "rdata held", 64'(rdata), 64'(p_data));
        end
        if (rvalid && rready) begin
          if (wp == rp) begin
            chk_eq("R5", "unexpected beat", 64'd1, 64'd0);
          end else begin
            chk_eq("R9", "rdata", 64'(rdata), 64'(pat(exp_wa[rp % 1024])));
            chk_eq("R9", "rid", 64'(rid), 64'(exp_id[rp % 1024]));
            chk_eq("R9", "rlast", 64'(rlast), 64'(exp_last[rp % 1024]));
            chk_eq("R10", "rresp", 64'(rresp), 64'd0);
            rp++;
          end
          if (!seen_first) begin first_cyc = cyc; seen_first = 1'b1; end
          last_cyc = cyc;
        end
        if (rvalid && !rready) chk_eq("R3", "strobe during stall", 64'(rd_stb), 64'd0);
        if (arvalid && arready) begin
          if (!(rvalid && !rready)) begin
            chk_eq("R3", "strobe at accept", 64'(rd_stb), 64'd1);
            chk_eq("R3", "first word addr", 64'(rd_word_addr), 64'(araddr[15:2]));
          end
          pa = araddr;
          for (int i = 0; i <= int'(arlen); i++) begin
            exp_wa[wp % 1024]   = pa[15:2];
            exp_id[wp % 1024]   = arid;
            exp_last[wp % 1024] = (i == int'(arlen));
            wp++;
            pa = exp_next(pa, arburst, arsize, arlen);
          end
        end
        p_stall = rvalid && !rready;
        p_last  = rlast;
        p_id    = rid;
        p_data  = rdata;
      end
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send_ar(input logic [15:0] a, input logic [7:0] l, input logic [2:0] s,
                         input logic [1:0] b, input logic [3:0] id);
    bit hs;
    arvalid = 1'b1; araddr = a; arlen = l; arsize = s; arburst = b; arid = id;
    hs = 1'b0;
    while (!hs) begin
      #3; hs = arready;
      @(negedge clk);
    end
  endtask

  task automatic ar_idle();
    arvalid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((wp != rp || rvalid) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    if (guard >= 5000) chk_eq("R5", "drain timeout", 64'(wp - rp), 64'd0);
    @(negedge clk);
    chk_eq("R5", "all beats returned", 64'(wp - rp), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk); #3;
    chk_eq("R1", "arready after reset", 64'(arready), 64'd1);
    chk_eq("R1", "rvalid after reset", 64'(rvalid), 64'd0);
    chk_eq("R1", "rlast after reset", 64'(rlast), 64'd0);
    chk_eq("R1", "no strobe after reset", 64'(rd_stb), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_ready_rule();
    rdy_mode = 1;
    @(negedge clk); @(negedge clk);
    send_ar(16'h0010, 8'd0, 3'd2, 2'b01, 4'd1);
    ar_idle(); #3;
    chk_eq("R2", "single beat keeps arready", 64'(arready), 64'd1);
    @(negedge clk);
    drain();
    send_ar(16'h0020, 8'd2, 3'd2, 2'b01, 4'd2);
    ar_idle(); #3;
    chk_eq("R2", "multi beat drops arready", 64'(arready), 64'd0);
    @(negedge clk);
    drain();
  endtask

  task automatic t_addressing();
    rdy_mode = 1;
    send_ar(16'h001C, 8'd3, 3'd2, 2'b10, 4'd3); ar_idle(); drain();   // R4 wrap 16 bytes
    send_ar(16'h0101, 8'd3, 3'd0, 2'b01, 4'd4); ar_idle(); drain();   // R4 narrow incr
    send_ar(16'h0203, 8'd2, 3'd1, 2'b01, 4'd5); ar_idle(); drain();   // R4 unaligned halfword
    send_ar(16'h0080, 8'd2, 3'd2, 2'b00, 4'd6); ar_idle(); drain();   // R4 fixed
    send_ar(16'h002E, 8'd7, 3'd1, 2'b10, 4'd7); ar_idle(); drain();   // R4 wrap halfword
  endtask

  task automatic t_back_to_back();
    int total;
    rdy_mode = 1;
    @(negedge clk); @(negedge clk);
    seen_first = 1'b0;
    total = 0;
    send_ar(16'h0300, 8'd0, 3'd2, 2'b01, 4'd1); total += 1;
    send_ar(16'h0304, 8'd0, 3'd2, 2'b00, 4'd2); total += 1;
    send_ar(16'h0308, 8'd0, 3'd2, 2'b01, 4'd3); total += 1;
    send_ar(16'h0310, 8'd1, 3'd2, 2'b01, 4'd4); total += 2;
    send_ar(16'h0320, 8'd2, 3'd2, 2'b01, 4'd5); total += 3;
    send_ar(16'h0334, 8'd3, 3'd2, 2'b10, 4'd6); total += 4;
    send_ar(16'h0340, 8'd0, 3'd2, 2'b01, 4'd7); total += 1;
    send_ar(16'h0380, 8'd7, 3'd2, 2'b01, 4'd8); total += 8;
    ar_idle();
    drain();
    chk_eq("R6", "beats back to back", 64'(last_cyc - first_cyc + 1), 64'(total));
  endtask

  task automatic t_stall_merge();
    rdy_mode = 0;
    @(negedge clk); @(negedge clk);
    send_ar(16'h0040, 8'd0, 3'd2, 2'b01, 4'd3);
    send_ar(16'h0400, 8'd255, 3'd2, 2'b01, 4'd5);     // R5: merged count 257
    arvalid = 1'b1; araddr = 16'h0900; arlen = 8'd1; arsize = 3'd2; arburst = 2'b01; arid = 4'd6;
    for (int k = 0; k < 4; k++) begin
      #3;
      chk_eq("R8", "arready low with two pending", 64'(arready), 64'd0);
      chk_eq("R8", "stalled beat valid", 64'(rvalid), 64'd1);
      chk_eq("R8", "stalled beat rid", 64'(rid), 64'd3);
      chk_eq("R8", "stalled beat rlast", 64'(rlast), 64'd1);
      @(negedge clk);
    end
    rdy_mode = 1;
    send_ar(16'h0900, 8'd1, 3'd2, 2'b01, 4'd6);
    ar_idle();
    drain();
  endtask

  task automatic t_random_ready();
    rdy_mode = 2;
    for (int k = 0; k < 6; k++) begin
      send_ar(16'h0500 + 16'(k * 64), 8'(k % 3), 3'd2, 2'b01, 4'(k));
      send_ar(16'h0600 + 16'(k * 4), 8'd0, 3'd2, 2'b01, 4'(k + 8));
      send_ar(16'h0708 + 16'(k * 32), 8'd3, 3'd2, 2'b10, 4'(k + 1));
      send_ar(16'h0801 + 16'(k * 16), 8'd4, 3'd0, 2'b01, 4'(k + 2));
    end
    ar_idle();
    drain();
  endtask

  task automatic t_final_idle();
    rdy_mode = 1;
    @(negedge clk); #3;
    chk_eq("R1", "idle arready", 64'(arready), 64'd1);
    chk_eq("R1", "idle rvalid", 64'(rvalid), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ready_rule();
    t_addressing();
    t_back_to_back();
    t_stall_merge();
    t_random_ready();
    t_final_idle();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule